// File: doc/BRIEF.md
# Seconds Counter Peripheral with Match Alarm

This block is a real-time-clock peripheral on a simple APB-style register bus. A prescaler divides the system clock into one tick per second. Each tick advances a free-running 32-bit seconds count, which wraps from all ones to zero. Software can read the count, load a new starting value and program a match value. The tick that brings the count onto the match value raises a sticky raw alarm flag. That flag, gated by a one-bit mask, drives a level interrupt.

A write to the load register restarts the prescaler, so the count moves on one full second after the load. The last eight words of the 4 KB window return fixed identification bytes. The control word always reads as enabled. Reads return data combinationally in the same cycle as the address. Writes take effect at the clock edge of the access phase, when `psel_i`, `penable_i` and `pwrite_i` are all high.

Top module: `rtc_sec_counter`

## Requirements
- R1: While reset is low and just after it, the count, match, load and mask registers and the raw flag all read 0, and `irq_o` is low. Reset is synchronous and active low.
- R2: With no load write, the count at word offset 0x00 rises by exactly 1 every PRESCALE clocks. It wraps from 0xFFFFFFFF to 0.
- R3: A write to offset 0x08 sets the count to the written value and restarts the prescaler, so the next increment comes PRESCALE clocks later. Offset 0x08 reads back the last value written. A load wins over a tick on the same edge.
- R4: Raw status at offset 0x14 (bit 0) is set by the tick that makes the count equal the match value. A load write or a match write never sets it. A match below the current count fires only after the count wraps.
- R5: Any write to offset 0x1C clears the raw flag, whatever the data. If a setting tick falls on the same edge, the set wins.
- R6: `irq_o` and the masked status at offset 0x18 (bit 0) equal the raw flag AND the mask bit. The mask at offset 0x10 keeps only bit 0, and its other bits read 0.
- R7: The control word at offset 0x0C reads 1, and writes to it change nothing.
- R8: Offsets 0xFE0, 0xFE4 and onward up to 0xFFC return in bits 7:0, in that order, 0x31, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1, with upper bits 0.
- R9: Offset 0x1C reads 0, unmapped offsets read 0, and writes to offsets 0x00, 0x14 and 0x18 are ignored.
- R10: The match value at offset 0x04 is writable and reads back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| psel_i | input | 1 | Peripheral select |
| penable_i | input | 1 | Access phase strobe |
| pwrite_i | input | 1 | 1 for write, 0 for read |
| paddr_i | input | ADDR_W | Byte address within the window |
| pwdata_i | input | 32 | Write data |
| prdata_o | output | 32 | Read data, valid while selected for read |
| irq_o | output | 1 | Level alarm interrupt |

## Verification
Two pairs of events can land on the same clock edge. The first pair is a second tick together with a load write. The second pair is a match-making tick together with a clear write. The bench provokes each pair by timing the write's access phase to land exactly PRESCALE edges after a load. The load pair is judged by the count holding the loaded value with no alarm, followed by a full second before the next increment. The clear pair is judged by the raw flag reading 1 after the edge, since the set must win. A separate clear write afterwards must bring the flag back to 0.

// File: rtl/rtc_sec_pkg.sv
package rtc_sec_pkg;
    localparam int DW = 32;

    // word indices of the register set (byte offset / 4)
    localparam int WI_COUNT = 0;
    localparam int WI_MATCH = 1;
    localparam int WI_LOAD  = 2;
    localparam int WI_CTRL  = 3;
    localparam int WI_MASK  = 4;
    localparam int WI_RAW   = 5;
    localparam int WI_MSTAT = 6;
    localparam int WI_CLR   = 7;

    typedef struct packed {
        logic [DW-1:0] cnt;
        logic [DW-1:0] match;
        logic [DW-1:0] load;
        logic          mask;
        logic          raw;
    } rtc_state_t;

    function automatic logic [7:0] id_byte(input logic [2:0] idx);
        case (idx)
            3'd0:    return 8'h31;
            3'd1:    return 8'h10;
            3'd2:    return 8'h14;
            3'd3:    return 8'h00;
            3'd4:    return 8'h0D;
            3'd5:    return 8'hF0;
            3'd6:    return 8'h05;
            default: return 8'hB1;
        endcase
    endfunction
endpackage

// File: rtl/rtc_tick_gen.sv
module rtc_tick_gen #(
    parameter int PRESCALE = 50_000_000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic restart_i,
    output logic tick_o
);
    localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

    logic [PW-1:0] pre_d, pre_q;

    assign tick_o = (pre_q == LAST);

    always_comb begin
        pre_d = pre_q + PW'(1);
        if (restart_i || tick_o) begin
            pre_d = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_d;
        end
    end

    // R2
    pre_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pre_q <= LAST);
    // R3
    pre_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        restart_i |=> (pre_q == '0));
endmodule

// File: rtl/rtc_count_core.sv
module rtc_count_core
    import rtc_sec_pkg::*;
(
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          tick_i,
    input  logic          load_we_i,
    input  logic          match_we_i,
    input  logic          mask_we_i,
    input  logic          clr_we_i,
    input  logic [DW-1:0] wdata_i,
    output rtc_state_t    state_o
);
    rtc_state_t    st_d, st_q;
    logic [DW-1:0] cnt_inc;
    logic          hit;

    assign cnt_inc = st_q.cnt + DW'(1);
    assign hit     = tick_i && !load_we_i && (cnt_inc == st_q.match);
    assign state_o = st_q;

    always_comb begin
        st_d = st_q;
        if (match_we_i) st_d.match = wdata_i;
        if (mask_we_i)  st_d.mask  = wdata_i[0];
        if (load_we_i) begin
            st_d.cnt  = wdata_i;
            st_d.load = wdata_i;
        end else if (tick_i) begin
            st_d.cnt = cnt_inc;
        end
        if (clr_we_i) st_d.raw = 1'b0;
        if (hit)      st_d.raw = 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R3
    cnt_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_we_i |=> (st_q.cnt == $past(wdata_i)));
    // R2
    cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && !load_we_i) |=> (st_q.cnt == $past(st_q.cnt) + DW'(1)));
    // R2
    cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!tick_i && !load_we_i) |=> $stable(st_q.cnt));
    // R4
    raw_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(st_q.raw) |-> ($past(tick_i) && !$past(load_we_i)));
    // R5
    raw_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_we_i && !tick_i) |=> !st_q.raw);
endmodule

// File: rtl/rtc_read_mux.sv
module rtc_read_mux
    import rtc_sec_pkg::*;
#(
    parameter int WORD_W = 10
) (
    input  logic              rd_en_i,
    input  logic [WORD_W-1:0] word_i,
    input  rtc_state_t        state_i,
    output logic [DW-1:0]     rdata_o
);
    logic in_id, in_regs;

    assign in_id   = &word_i[WORD_W-1:3];
    assign in_regs = (word_i[WORD_W-1:3] == '0);

    always_comb begin
        rdata_o = '0;
        if (rd_en_i && in_id) begin
            rdata_o = {{(DW-8){1'b0}}, id_byte(word_i[2:0])};
        end else if (rd_en_i && in_regs) begin
            case (int'(word_i[2:0]))
                WI_COUNT: rdata_o = state_i.cnt;
                WI_MATCH: rdata_o = state_i.match;
                WI_LOAD:  rdata_o = state_i.load;
                WI_CTRL:  rdata_o = DW'(1);
                WI_MASK:  rdata_o = DW'(state_i.mask);
                WI_RAW:   rdata_o = DW'(state_i.raw);
                WI_MSTAT: rdata_o = DW'(state_i.raw & state_i.mask);
                default:  rdata_o = '0;
            endcase
        end
    end
endmodule

// File: rtl/rtc_sec_counter.sv
module rtc_sec_counter
    import rtc_sec_pkg::*;
#(
    parameter int PRESCALE = 50_000_000,
    parameter int ADDR_W   = 12
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              psel_i,
    input  logic              penable_i,
    input  logic              pwrite_i,
    input  logic [ADDR_W-1:0] paddr_i,
    input  logic [DW-1:0]     pwdata_i,
    output logic [DW-1:0]     prdata_o,
    output logic              irq_o
);
    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word;
    logic [1:0]        addr_lo_unused;
    logic              wr_en, rd_en, tick;
    logic              load_we, match_we, mask_we, clr_we;
    rtc_state_t        state;

    assign word           = paddr_i[ADDR_W-1:2];
    assign addr_lo_unused = paddr_i[1:0];
    assign wr_en          = psel_i && penable_i && pwrite_i;
    assign rd_en          = psel_i && !pwrite_i;
    assign load_we        = wr_en && (word == WORD_W'(WI_LOAD));
    assign match_we       = wr_en && (word == WORD_W'(WI_MATCH));
    assign mask_we        = wr_en && (word == WORD_W'(WI_MASK));
    assign clr_we         = wr_en && (word == WORD_W'(WI_CLR));

    rtc_tick_gen #(.PRESCALE(PRESCALE)) tick_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .restart_i (load_we),
        .tick_o    (tick)
    );

    rtc_count_core core_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .tick_i     (tick),
        .load_we_i  (load_we),
        .match_we_i (match_we),
        .mask_we_i  (mask_we),
        .clr_we_i   (clr_we),
        .wdata_i    (pwdata_i),
        .state_o    (state)
    );

    rtc_read_mux #(.WORD_W(WORD_W)) rmux_i (
        .rd_en_i (rd_en),
        .word_i  (word),
        .state_i (state),
        .rdata_o (prdata_o)
    );

    assign irq_o = state.raw & state.mask;

    // R6
    irq_mstat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_en && word == WORD_W'(WI_MSTAT)) |-> (prdata_o[0] == irq_o));
    // R7
    ctrl_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_en && word == WORD_W'(WI_CTRL)) |-> (prdata_o == DW'(1)));
endmodule

// File: tb/rtc_sec_counter_tb.sv
`timescale 1ns/1ps
module rtc_sec_counter_tb_top;
    localparam int P  = 16;
    localparam int NV = 19;
    // {byte address, expected read data} while reset is held
    localparam logic [43:0] RD_VEC [NV] = '{
        {12'h000, 32'h0}, {12'h004, 32'h0}, {12'h008, 32'h0},
        {12'h00C, 32'h1}, {12'h010, 32'h0}, {12'h014, 32'h0},
        {12'h018, 32'h0}, {12'h01C, 32'h0},
        {12'hFE0, 32'h31}, {12'hFE4, 32'h10}, {12'hFE8, 32'h14},
        {12'hFEC, 32'h00}, {12'hFF0, 32'h0D}, {12'hFF4, 32'hF0},
        {12'hFF8, 32'h05}, {12'hFFC, 32'hB1},
        {12'h020, 32'h0}, {12'h800, 32'h0}, {12'hFDC, 32'h0}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        psel, penable, pwrite;
    logic [11:0] paddr;
    logic [31:0] pwdata, prdata;
    logic        irq;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    rtc_sec_counter #(.PRESCALE(P), .ADDR_W(12)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .psel_i(psel), .penable_i(penable),
        .pwrite_i(pwrite), .paddr_i(paddr), .pwdata_i(pwdata),
        .prdata_o(prdata), .irq_o(irq)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    // called just after a negedge; write lands on the second posedge
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
        @(posedge clk);
        @(negedge clk);
        penable = 1'b1;
        @(posedge clk);
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a;
        #0.1;
        d = prdata;
        psel = 1'b0;
    endtask

    task automatic rchk(input string tag, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(tag, d, exp);
    endtask

    task automatic settle(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        psel = 0; penable = 0; pwrite = 0; paddr = '0; pwdata = '0;
        rst_n = 1'b0;
        settle(3);
        // table walk while reset holds the state: R1, R7, R8, R9
        for (int i = 0; i < NV; i++) begin
            logic [11:0] a;
            a = RD_VEC[i][43:32];
            if (a >= 12'hFE0)      rchk("R8", a, RD_VEC[i][31:0]);
            else if (a == 12'h00C) rchk("R7", a, RD_VEC[i][31:0]);
            else if (a >= 12'h01C) rchk("R9", a, RD_VEC[i][31:0]);
            else                   rchk("R1", a, RD_VEC[i][31:0]);
            @(negedge clk);
        end
        chk("R1 irq", {31'b0, irq}, 32'h0);
        rst_n = 1'b1;
        rchk("R1 count after release", 12'h000, 32'h0);

        wr(12'h004, 32'h5555);
        rchk("R10 match readback", 12'h004, 32'h5555);

        // R2: one step per P clocks after a load
        wr(12'h008, 32'h10);
        settle(P - 1);
        rchk("R2 before tick", 12'h000, 32'h10);
        settle(1);
        rchk("R2 first tick", 12'h000, 32'h11);
        rchk("R3 load readback", 12'h008, 32'h10);
        settle(2 * P);
        rchk("R2 three ticks", 12'h000, 32'h13);

        // R2: wrap
        wr(12'h008, 32'hFFFF_FFFF);
        settle(P);
        rchk("R2 wrap", 12'h000, 32'h0);
        rchk("R4 no match", 12'h014, 32'h0);

        // R4: alarm after three ticks
        wr(12'h010, 32'h1);
        wr(12'h004, 32'd103);
        wr(12'h008, 32'd100);
        settle(3 * P - 1);
        rchk("R4 not yet", 12'h014, 32'h0);
        chk("R6 irq low", {31'b0, irq}, 32'h0);
        settle(1);
        rchk("R4 fired", 12'h014, 32'h1);
        chk("R6 irq high", {31'b0, irq}, 32'h1);
        rchk("R6 masked", 12'h018, 32'h1);
        wr(12'h01C, 32'h0);
        rchk("R5 clear zero data", 12'h014, 32'h0);
        chk("R6 irq after clear", {31'b0, irq}, 32'h0);

        // R6: mask gating
        wr(12'h010, 32'hFFFF_FFFE);
        wr(12'h004, 32'd201);
        wr(12'h008, 32'd200);
        settle(P);
        rchk("R4 raw set", 12'h014, 32'h1);
        chk("R6 masked irq", {31'b0, irq}, 32'h0);
        rchk("R6 masked status", 12'h018, 32'h0);
        rchk("R6 mask bit", 12'h010, 32'h0);
        wr(12'h010, 32'hFFFF_FFFF);
        rchk("R6 mask upper bits", 12'h010, 32'h1);
        chk("R6 unmasked irq", {31'b0, irq}, 32'h1);
        wr(12'h01C, 32'hA5A5_A5A4);
        rchk("R5 clear any data", 12'h014, 32'h0);

        // R4: match below count does not fire
        wr(12'h004, 32'd5);
        wr(12'h008, 32'd10);
        settle(4 * P);
        rchk("R4 below count cnt", 12'h000, 32'd14);
        rchk("R4 below count raw", 12'h014, 32'h0);

        // R4: fires after wrap
        wr(12'h004, 32'h0);
        wr(12'h008, 32'hFFFF_FFFE);
        settle(2 * P - 1);
        rchk("R4 wrap pending", 12'h014, 32'h0);
        settle(1);
        rchk("R4 wrap fired", 12'h014, 32'h1);
        rchk("R2 wrap count", 12'h000, 32'h0);
        wr(12'h01C, 32'h0);

        // R3: load on the tick edge wins and does not fire
        wr(12'h004, 32'd51);
        wr(12'h008, 32'd50);
        settle(P - 2);
        wr(12'h008, 32'd51);
        rchk("R3 load beats tick", 12'h000, 32'd51);
        rchk("R4 load no fire", 12'h014, 32'h0);
        settle(P - 1);
        rchk("R3 restart hold", 12'h000, 32'd51);
        settle(1);
        rchk("R3 restart step", 12'h000, 32'd52);

        // R5: set beats clear on the same edge
        wr(12'h004, 32'd301);
        wr(12'h008, 32'd300);
        settle(P - 2);
        wr(12'h01C, 32'h1);
        rchk("R5 set wins", 12'h014, 32'h1);
        wr(12'h01C, 32'h1);
        rchk("R5 clear after", 12'h014, 32'h0);

        // R7, R9: ignored writes; R4 match write does not fire
        wr(12'h008, 32'd700);
        wr(12'h00C, 32'h0);
        rchk("R7 ctrl stays 1", 12'h00C, 32'h1);
        wr(12'h000, 32'hDEAD_BEEF);
        wr(12'h014, 32'h1);
        wr(12'h018, 32'h1);
        rchk("R9 count unchanged", 12'h000, 32'd700);
        rchk("R9 raw unchanged", 12'h014, 32'h0);
        rchk("R9 masked unchanged", 12'h018, 32'h0);
        wr(12'h004, 32'd700);
        rchk("R4 match write no fire", 12'h014, 32'h0);
        rchk("R9 unmapped", 12'h020, 32'h0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog (all requirements) actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule